// File: doc/BRIEF.md
# Boundary-Splitting DMA Descriptor Builder

This block converts a stream of memory segments, each given as a start address and a byte length, into a table of 16-byte descriptors that a DMA engine walks. No descriptor may span a 64 KiB-aligned address window. A segment that would cross such a boundary is therefore cut into pieces. The first piece runs up to the next boundary. Each later piece covers one full window, until the segment is used up. Every descriptor is written into the table as four 32-bit words, in big-endian byte order, one word per cycle through a simple write port.

A run begins with a `start` pulse. The block then accepts segments over a valid/ready handshake. The list ends at a segment flagged as last, or at the first zero-length segment. When the list ends, the block rewrites the length word of the final descriptor with the end-of-list bit set. It then pulses `done` and reports the number of descriptors.

If the list needs more descriptors than the table holds, or contains no data at all, the block reports zero descriptors and raises `fallback`. The caller should then use a non-DMA transfer. Input ready stays low from the end of a run until the next `start`.

Top module: `desc_list_gen`

## Requirements
- R1: After reset `seg_ready`, `wr_en`, `done` and `fallback` are 0, and `desc_count` is 0.
- R2: `seg_ready` rises only in the cycle after a `start` pulse or after a descriptor sequence completes mid-list. It is 0 while descriptor words are being written. It stays 0 from the final segment's acceptance until the next `start`.
- R3: For each piece, the length is min(0x10000 − (address mod 0x10000), remaining bytes). The next piece starts at the address plus that length.
- R4: Descriptor n occupies table word indices 4n..4n+3, written in that order, with the values 0, the piece address, 0 and the piece length. The length sits in bits 16:0 of the value.
- R5: Every word is presented byte-swapped on `wr_data`. Value bits 7:0 appear on `wr_data[31:24]`, bits 15:8 on `wr_data[23:16]`, bits 23:16 on `wr_data[15:8]` and bits 31:24 on `wr_data[7:0]`.
- R6: When a list with at least one descriptor ends, exactly one extra write goes to index 4(N−1)+3. It carries the last length value OR 0x8000_0000, and no other written value has bit 31 set.
- R7: A zero-length segment is accepted, produces no descriptor and ends the list. The segments that follow it are not accepted.
- R8: A list that yields no descriptor ends with `done`, `desc_count` = 0 and `fallback` = 1, and no end-of-list write.
- R9: If a piece would need descriptor number MAX_DESC+1 (65 by default), output stops without an end-of-list write and `done` comes with `desc_count` = 0 and `fallback` = 1. Exactly MAX_DESC descriptors completes normally.
- R10: `done` is high for one cycle. `desc_count` and `fallback` take their new values in that cycle and hold them until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a new list (ignored while a run is in progress) |
| seg_valid | input | 1 | Segment offered |
| seg_ready | output | 1 | Segment accepted when high together with `seg_valid` |
| seg_addr | input | ADDR_W | Segment start address |
| seg_len | input | LEN_W | Segment length in bytes; 0 ends the list |
| seg_last | input | 1 | Segment is the final one of the list |
| wr_en | output | 1 | Table word write strobe |
| wr_idx | output | IDX_W | Table word index |
| wr_data | output | 32 | Byte-swapped table word |
| done | output | 1 | One-cycle end-of-run pulse |
| desc_count | output | CNT_W | Descriptors produced (0 on fallback) |
| fallback | output | 1 | Table overflow or empty list |

## Verification
Wrong piece arithmetic shows within one descriptor. The address word of the next piece, or its length word, differs from the scoreboard four write cycles after the piece starts. A wrong word counter or descriptor counter shows at once as a write at the wrong index. A missing or misplaced end-of-list write shows within one cycle of the last length word, or of the zero-length segment. A table-full test that is off by one shows only at the 64-descriptor and 65-descriptor lists, so both lists are run.

// File: rtl/dlg_pkg.sv
package dlg_pkg;
   localparam int WORD_W         = 32;
   localparam int WORDS_PER_DESC = 4;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_TAKE,
      ST_EMIT,
      ST_SEAL
   } dlg_state_e;

   typedef enum logic [1:0] {
      WK_ZERO,
      WK_ADDR,
      WK_LEN,
      WK_SEAL
   } word_kind_e;
endpackage

// File: rtl/dlg_chunker.sv
module dlg_chunker #(
   parameter int LEN_W   = 24,
   parameter int BOUND_W = 16,
   localparam int CH_W   = BOUND_W + 1,
   localparam int CMP_W  = (LEN_W > CH_W) ? LEN_W : CH_W
) (
   input  logic [BOUND_W-1:0] addr_lo,
   input  logic [LEN_W-1:0]   remain,
   output logic [CH_W-1:0]    chunk
);
   logic [CH_W-1:0]  room;
   logic [CMP_W-1:0] room_w;
   logic [CMP_W-1:0] rem_w;

   if (BOUND_W < 1) begin : g_bad_bound
      $error("dlg_chunker: BOUND_W must be at least 1");
   end

   // bytes left before the next aligned window boundary
   assign room   = {1'b1, {BOUND_W{1'b0}}} - {1'b0, addr_lo};
   assign room_w = CMP_W'(room);
   assign rem_w  = CMP_W'(remain);
   assign chunk  = (rem_w < room_w) ? CH_W'(remain) : room;
endmodule

// File: rtl/dlg_word_fmt.sv
module dlg_word_fmt
   import dlg_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int BOUND_W    = 16,
   parameter bit BIG_ENDIAN = 1'b1
) (
   input  word_kind_e          kind,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [BOUND_W:0]    chunk,
   input  logic [WORD_W-1:0]   held_len,
   output logic [WORD_W-1:0]   len_word,
   output logic [WORD_W-1:0]   wr_data
);
   localparam int NBYTES = WORD_W / 8;
   logic [WORD_W-1:0] raw;

   if (ADDR_W > WORD_W) begin : g_bad_addr
      $error("dlg_word_fmt: ADDR_W exceeds the table word width");
   end
   if (BOUND_W + 1 >= WORD_W) begin : g_bad_len
      $error("dlg_word_fmt: length field collides with end-of-list bit");
   end

   assign len_word = WORD_W'(chunk);

   always_comb begin
      unique case (kind)
         WK_ADDR: raw = WORD_W'(addr);
         WK_LEN:  raw = len_word;
         WK_SEAL: raw = held_len | {1'b1, {(WORD_W-1){1'b0}}};
         default: raw = '0;
      endcase
   end

   if (BIG_ENDIAN) begin : g_swap
      for (genvar b = 0; b < NBYTES; b++) begin : g_byte
         assign wr_data[8*b +: 8] = raw[WORD_W-8-8*b +: 8];
      end
   end else begin : g_native
      assign wr_data = raw;
   end
endmodule

// File: rtl/desc_list_gen.sv
module desc_list_gen
   import dlg_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LEN_W      = 24,
   parameter int BOUND_W    = 16,
   parameter int MAX_DESC   = 64,
   parameter bit BIG_ENDIAN = 1'b1,
   localparam int IDX_W     = $clog2(MAX_DESC * WORDS_PER_DESC),
   localparam int CNT_W     = $clog2(MAX_DESC + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              seg_valid,
   output logic              seg_ready,
   input  logic [ADDR_W-1:0] seg_addr,
   input  logic [LEN_W-1:0]  seg_len,
   input  logic              seg_last,
   output logic              wr_en,
   output logic [IDX_W-1:0]  wr_idx,
   output logic [WORD_W-1:0] wr_data,
   output logic              done,
   output logic [CNT_W-1:0]  desc_count,
   output logic              fallback
);
   localparam int WSEL_W = $clog2(WORDS_PER_DESC);
   localparam int CH_W   = BOUND_W + 1;
   localparam logic [WSEL_W-1:0] WSEL_ADDR = WSEL_W'(1);
   localparam logic [WSEL_W-1:0] WSEL_LEN  = WSEL_W'(WORDS_PER_DESC - 1);

   if (MAX_DESC < 1) begin : g_bad_depth
      $error("desc_list_gen: MAX_DESC must be at least 1");
   end
   if (BOUND_W >= ADDR_W) begin : g_bad_bound
      $error("desc_list_gen: BOUND_W must be below ADDR_W");
   end

   dlg_state_e        state;
   logic [ADDR_W-1:0] cur_addr;
   logic [LEN_W-1:0]  rem_len;
   logic              seg_is_last;
   logic [WSEL_W-1:0] wsel;
   logic [CNT_W-1:0]  desc_n;
   logic [WORD_W-1:0] held_len;
   logic              done_q;
   logic [CNT_W-1:0]  count_q;
   logic              fb_q;

   logic [CH_W-1:0]   chunk;
   logic [WORD_W-1:0] len_word;
   logic [LEN_W-1:0]  rem_next;
   logic              table_full;
   word_kind_e        kind;

   dlg_chunker #(
      .LEN_W   (LEN_W),
      .BOUND_W (BOUND_W)
   ) u_chunker (
      .addr_lo (cur_addr[BOUND_W-1:0]),
      .remain  (rem_len),
      .chunk   (chunk)
   );

   dlg_word_fmt #(
      .ADDR_W     (ADDR_W),
      .BOUND_W    (BOUND_W),
      .BIG_ENDIAN (BIG_ENDIAN)
   ) u_fmt (
      .kind     (kind),
      .addr     (cur_addr),
      .chunk    (chunk),
      .held_len (held_len),
      .len_word (len_word),
      .wr_data  (wr_data)
   );

   assign table_full = (desc_n == CNT_W'(MAX_DESC));
   assign rem_next   = rem_len - LEN_W'(chunk);

   always_comb begin
      kind = WK_ZERO;
      if (state == ST_SEAL) begin
         kind = WK_SEAL;
      end else if (wsel == WSEL_ADDR) begin
         kind = WK_ADDR;
      end else if (wsel == WSEL_LEN) begin
         kind = WK_LEN;
      end
   end

   always_comb begin
      wr_en  = 1'b0;
      wr_idx = IDX_W'({desc_n, wsel});
      if (state == ST_EMIT) begin
         wr_en = !((wsel == '0) && table_full);
      end else if (state == ST_SEAL) begin
         wr_en  = 1'b1;
         wr_idx = IDX_W'({desc_n - 1'b1, WSEL_LEN});
      end
   end

   assign seg_ready  = (state == ST_TAKE);
   assign done       = done_q;
   assign desc_count = count_q;
   assign fallback   = fb_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         cur_addr    <= '0;
         rem_len     <= '0;
         seg_is_last <= 1'b0;
         wsel        <= '0;
         desc_n      <= '0;
         held_len    <= '0;
         done_q      <= 1'b0;
         count_q     <= '0;
         fb_q        <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  desc_n <= '0;
                  state  <= ST_TAKE;
               end
            end
            ST_TAKE: begin
               if (seg_valid) begin
                  if (seg_len == '0) begin
                     if (desc_n == '0) begin
                        done_q  <= 1'b1;
                        count_q <= '0;
                        fb_q    <= 1'b1;
                        state   <= ST_IDLE;
                     end else begin
                        state <= ST_SEAL;
                     end
                  end else begin
                     cur_addr    <= seg_addr;
                     rem_len     <= seg_len;
                     seg_is_last <= seg_last;
                     wsel        <= '0;
                     state       <= ST_EMIT;
                  end
               end
            end
            ST_EMIT: begin
               if ((wsel == '0) && table_full) begin
                  done_q  <= 1'b1;
                  count_q <= '0;
                  fb_q    <= 1'b1;
                  state   <= ST_IDLE;
               end else begin
                  wsel <= wsel + 1'b1;
                  if (wsel == WSEL_LEN) begin
                     held_len <= len_word;
                     desc_n   <= desc_n + 1'b1;
                     cur_addr <= cur_addr + ADDR_W'(chunk);
                     rem_len  <= rem_next;
                     if (rem_next == '0) begin
                        state <= seg_is_last ? ST_SEAL : ST_TAKE;
                     end
                  end
               end
            end
            ST_SEAL: begin
               done_q  <= 1'b1;
               count_q <= desc_n;
               fb_q    <= 1'b0;
               state   <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/desc_list_gen_chk.sv
module desc_list_gen_chk #(
   parameter int IDX_W = 8,
   parameter int CNT_W = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             seg_ready,
   input logic             wr_en,
   input logic [IDX_W-1:0] wr_idx,
   input logic             done,
   input logic [CNT_W-1:0] desc_count,
   input logic             fallback
);
   // R2
   ready_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(seg_ready) |-> ($past(start) || $past(wr_en)));

   // R2
   ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !seg_ready);

   // R4
   word_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx[1:0] == 2'd1) |-> ($past(wr_en) && $past(wr_idx) == wr_idx - 1'b1));

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(desc_count) && $stable(fallback)));

   // R9
   fallback_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && fallback) |-> (desc_count == '0));
endmodule

bind desc_list_gen desc_list_gen_chk #(
   .IDX_W (IDX_W),
   .CNT_W (CNT_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .seg_ready  (seg_ready),
   .wr_en      (wr_en),
   .wr_idx     (wr_idx),
   .done       (done),
   .desc_count (desc_count),
   .fallback   (fallback)
);

// File: tb/desc_list_gen_bench.sv
`timescale 1ns/1ps
module desc_list_gen_bench;
   localparam int IDX_W = 8;
   localparam int CNT_W = 7;
   localparam int MAXD  = 64;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic              seg_valid = 1'b0;
   logic              seg_ready;
   logic [31:0]       seg_addr = '0;
   logic [23:0]       seg_len = '0;
   logic              seg_last = 1'b0;
   logic              wr_en;
   logic [IDX_W-1:0]  wr_idx;
   logic [31:0]       wr_data;
   logic              done;
   logic [CNT_W-1:0]  desc_count;
   logic              fallback;

   int checks = 0;
   int errors = 0;
   int done_seen = 0;
   int cycles = 0;
   logic prev_done = 1'b0;

   int          exp_idx_q[$];
   logic [31:0] exp_dat_q[$];
   string       exp_tag_q[$];
   int          exp_cnt_q[$];
   logic        exp_fb_q[$];
   int          last_cnt = 0;

   int          sa[8];
   int          sl[8];

   always #5 clk = ~clk;

   desc_list_gen u_desc_list_gen (
      .clk(clk), .rst_n(rst_n), .start(start),
      .seg_valid(seg_valid), .seg_ready(seg_ready),
      .seg_addr(seg_addr), .seg_len(seg_len), .seg_last(seg_last),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .done(done), .desc_count(desc_count), .fallback(fallback)
   );

   function automatic logic [31:0] bswap(input logic [31:0] v);
      return {v[7:0], v[15:8], v[23:16], v[31:24]};
   endfunction

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic push_word(input int idx, input logic [31:0] val, input string tag);
      exp_idx_q.push_back(idx);
      exp_dat_q.push_back(bswap(val));
      exp_tag_q.push_back(tag);
   endtask

   // monitor: pops expected writes and results as the design produces them
   always @(negedge clk) begin
      if (rst_n) begin
         if (wr_en) begin
            if (exp_idx_q.size() == 0) begin
               check(1'b0, "R7 unexpected write", longint'(wr_idx), 0);
            end else begin
               int    ei;
               logic [31:0] ed;
               string et;
               ei = exp_idx_q.pop_front();
               ed = exp_dat_q.pop_front();
               et = exp_tag_q.pop_front();
               check(int'(wr_idx) == ei, {et, " index"}, longint'(wr_idx), longint'(ei));
               check(wr_data == ed, {et, " data"}, longint'(wr_data), longint'(ed));
            end
         end
         if (done) begin
            check(!prev_done, "R10 done width", 1, 0);
            if (exp_cnt_q.size() == 0) begin
               check(1'b0, "R10 unexpected done", 1, 0);
            end else begin
               int   ec;
               logic ef;
               ec = exp_cnt_q.pop_front();
               ef = exp_fb_q.pop_front();
               check(int'(desc_count) == ec, "R10 count", longint'(desc_count), longint'(ec));
               check(fallback == ef, "R8 R9 fallback", longint'(fallback), longint'(ef));
            end
            done_seen++;
         end
         prev_done <= done;
      end
   end

   // driver: build the expected items, then present the segments
   task automatic run_list(input int n, input string tag);
      int  cnt = 0;
      bit  ovf = 0;
      int  last_len = 0;
      int  seen;
      for (int i = 0; i < n && !ovf; i++) begin
         longint a = longint'(sa[i]) & 64'hFFFF_FFFF;
         longint r = longint'(sl[i]);
         if (r == 0) break;
         while (r > 0) begin
            longint room;
            longint ch;
            if (cnt == MAXD) begin
               ovf = 1;
               break;
            end
            room = 65536 - (a & 65535);
            ch = (r < room) ? r : room;
            push_word(cnt*4,     32'h0,                  {tag, " R4 word0"});
            push_word(cnt*4 + 1, 32'(a),                 {tag, " R3 R5 addr"});
            push_word(cnt*4 + 2, 32'h0,                  {tag, " R4 word2"});
            push_word(cnt*4 + 3, 32'(ch),                {tag, " R3 R5 len"});
            last_len = int'(ch);
            a = (a + ch) & 64'hFFFF_FFFF;
            r = r - ch;
            cnt++;
         end
      end
      if (ovf || cnt == 0) begin
         exp_cnt_q.push_back(0);
         exp_fb_q.push_back(1'b1);
         last_cnt = 0;
      end else begin
         push_word((cnt-1)*4 + 3, 32'(last_len) | 32'h8000_0000, {tag, " R6 seal"});
         exp_cnt_q.push_back(cnt);
         exp_fb_q.push_back(1'b0);
         last_cnt = cnt;
      end

      seen = done_seen;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < n; i++) begin
         bit r;
         seg_valid = 1'b1;
         seg_addr  = sa[i];
         seg_len   = 24'(sl[i]);
         seg_last  = (i == n - 1);
         forever begin
            r = seg_ready;
            @(negedge clk);
            if (r) break;
         end
         if (sl[i] == 0) break;
      end
      // keep offering a segment; none may be taken after the list ended
      seg_addr = 32'hDEAD_0000;
      seg_len  = 24'h100;
      seg_last = 1'b1;
      while (done_seen == seen) begin
         check(!seg_ready, {tag, " R2 R7 ready low after end"}, longint'(seg_ready), 0);
         @(negedge clk);
      end
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         check(!seg_ready, {tag, " R2 ready held low"}, longint'(seg_ready), 0);
         check(int'(desc_count) == last_cnt, {tag, " R10 count held"}, longint'(desc_count), longint'(last_cnt));
      end
      seg_valid = 1'b0;
      check(exp_idx_q.size() == 0, {tag, " R4 all writes seen"}, longint'(exp_idx_q.size()), 0);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      check(!seg_ready && !wr_en && !done, "R1 reset outputs", {seg_ready, wr_en, done}, 0);
      check(desc_count == '0 && !fallback, "R1 reset result", longint'(desc_count), 0);

      sa[0] = 32'h1000_0000; sl[0] = 32'h200;
      run_list(1, "aligned");

      sa[0] = 32'h0001_FF00; sl[0] = 32'h300;
      run_list(1, "crossing");

      sa[0] = 32'h4000_0000; sl[0] = 32'h1_0000;
      sa[1] = 32'h5000_8000; sl[1] = 32'h1_8000;
      sa[2] = 32'h0000_FFFF; sl[2] = 32'h2;
      run_list(3, "multi");

      sa[0] = 32'h0000_0100; sl[0] = 32'h40;
      sa[1] = 32'h0;         sl[1] = 0;
      sa[2] = 32'h2000_0000; sl[2] = 32'h80;
      run_list(3, "R7 zero-term");

      sa[0] = 32'h0; sl[0] = 0;
      run_list(1, "R8 empty");

      sa[0] = 32'h0; sl[0] = 64 * 65536;
      run_list(1, "R9 exactly full");

      sa[0] = 32'h0; sl[0] = 65 * 65536;
      run_list(1, "R9 overflow");

      sa[0] = 32'h3000_F000; sl[0] = 32'h1000;
      run_list(1, "after fallback");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule